// File: doc/BRIEF.md
# Programmable serial CRC engine

The block computes a cyclic redundancy check one message bit per clock. The polynomial is set at run time by two values: a degree field, which gives the CRC width minus one, and a feedback mask. The mask holds every term of the polynomial except the top term, which is always one and is implied. The engine performs plain long division of the augmented message. The caller therefore follows the message with as many zero bits as the CRC is wide, and the register then holds the remainder.

A host drives a small write port with four addresses:

| Address | Meaning |
|---|---|
| 0 | Push a data word into an 8-word input FIFO. |
| 1 | Control: bits 3:0 hold the degree, bit 4 is the run bit. |
| 2 | Feedback mask. |
| 3 | Starting value of the result. |

While the run bit is set, the engine takes words from the FIFO. It shifts the low (degree+1) bits of each word in, most significant first. The host watches the full and empty flags. It waits for empty, clears the run bit, and reads the result. The result is shown with its unused upper bits forced to zero.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset, crc_out is 0, fifo_empty is 1 and fifo_full is 0, and the run bit is clear.
- R2: A control write sets the degree field L from wr_data[3:0], so the CRC is L+1 bits wide. Each data word contributes its bits L down to 0, bit L first. Bits above L are ignored.
- R3: Each step does the following, in order:
  - Remember bit L of the register.
  - Shift the register left by one and put the message bit in at bit 0.
  - Clear the bits above L.
  - If the remembered bit was 1, XOR in the feedback mask, restricted to bits L..0.
- R4: While the run bit is set and work is available, exactly one bit is consumed per clock, with no gap between words. Two 16-bit words take 32 clocks from run to empty.
- R5: With the run bit clear, the result does not change and the FIFO keeps its words.
- R6: A write to address 3 sets the starting value of the result, when that write is allowed (R9).
- R7: The FIFO holds 8 words. fifo_full is 1 while it holds 8 words. A data write while full is dropped.
- R8: fifo_empty is 1 only when the FIFO is empty and no word is partly shifted.
- R9: While the run bit is set and fifo_empty is 0, writes to the degree field, the mask and the result are ignored. The run bit itself can always be written.
- R10: crc_out shows the register with bits above L forced to 0.
- R11: Take degree 15, mask 0x1021 and a start value of 0. The words 0x0051 and 0x0000 then give 0x4AD4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 data, 1 control, 2 mask, 3 start value |
| wr_data | input | 16 | Write data |
| crc_out | output | 16 | Result, with the upper bits masked |
| fifo_full | output | 1 | FIFO holds 8 words |
| fifo_empty | output | 1 | FIFO is empty and the shifter is idle |

## Verification
The assertions check several behaviours on every cycle:
- the FIFO never overflows;
- a dropped write leaves the FIFO full;
- the empty flag agrees with the FIFO count and the shifter state;
- the result holds while the run bit is clear;
- the mask is frozen during a run.

The bench scenarios show the properties that depend on whole sequences. These are:
- the remainder values;
- the known vector;
- the gap-free 32-clock timing across two words;
- pause and resume;
- the 8-bit width with ignored upper data bits;
- the dropped ninth word.

The bench shows each of these by comparing against an independent model on every clock.

// File: rtl/crc_pkg.sv
package crc_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_MASK = 2'd2,
    ADDR_INIT = 2'd3
  } crc_addr_e;

  localparam int CTRL_GO_BIT = 4;
endpackage

// File: rtl/crc_fifo.sv
module crc_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign dout    = mem[rd_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = wr_q + AW'(1);
    if (do_pop)  rd_d = rd_q + AW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/crc_feeder.sv
module crc_feeder #(
  parameter int W    = 16,
  localparam int LW  = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [LW-1:0] len,
  input  logic          src_empty,
  input  logic [W-1:0]  src_word,
  output logic          pop,
  output logic          step_en,
  output logic          bit_out,
  output logic          busy
);
  logic [W-1:0]  word_q, word_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  assign busy    = busy_q;
  assign pop     = run && !busy_q && !src_empty;
  assign step_en = run && (busy_q || !src_empty);
  assign bit_out = busy_q ? word_q[cnt_q] : src_word[len];

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (pop) begin
      word_d = src_word;
      cnt_d  = len - LW'(1);
      busy_d = (len != '0);
    end else if (step_en) begin
      cnt_d  = cnt_q - LW'(1);
      busy_d = (cnt_q != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/crc_lfsr.sv
module crc_lfsr #(
  parameter int W    = 16,
  localparam int LW  = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          bit_in,
  input  logic          load_en,
  input  logic [W-1:0]  load_val,
  input  logic [LW-1:0] len,
  input  logic [W-1:0]  mask,
  output logic [W-1:0]  crc_raw,
  output logic [W-1:0]  crc_res
);
  localparam logic [LW-1:0] TOP = LW'(W - 1);

  logic [W-1:0] crc_q, crc_d, wmask, shifted;
  logic         msb;

  assign wmask   = {W{1'b1}} >> (TOP - len);
  assign msb     = crc_q[len];
  assign shifted = {crc_q[W-2:0], bit_in} & wmask;
  assign crc_raw = crc_q;
  assign crc_res = crc_q & wmask;

  always_comb begin
    crc_d = crc_q;
    if (step_en)      crc_d = msb ? (shifted ^ (mask & wmask)) : shifted;
    else if (load_en) crc_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(W),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] crc_out,
  output logic         fifo_full,
  output logic         fifo_empty
);
  import crc_pkg::*;

  logic          rs1_q, rst_sync_n;
  logic          go_q, go_d;
  logic [LW-1:0] len_q, len_d;
  logic [W-1:0]  mask_q, mask_d;
  logic          sel_data, sel_ctrl, sel_mask, sel_init, locked;
  logic [W-1:0]  head;
  logic          q_empty, pop, step_en, bit_s, busy;
  logic [CW-1:0] fifo_cnt;
  logic [W-1:0]  crc_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs1_q      <= 1'b1;
      rst_sync_n <= rs1_q;
    end
  end

  assign fifo_empty = q_empty && !busy;
  assign locked     = go_q && !fifo_empty;
  assign sel_data   = wr_en && (wr_addr == ADDR_DATA);
  assign sel_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
  assign sel_mask   = wr_en && (wr_addr == ADDR_MASK) && !locked;
  assign sel_init   = wr_en && (wr_addr == ADDR_INIT) && !locked;

  always_comb begin
    go_d   = go_q;
    len_d  = len_q;
    mask_d = mask_q;
    if (sel_ctrl) begin
      go_d = wr_data[CTRL_GO_BIT];
      if (!locked) len_d = wr_data[LW-1:0];
    end
    if (sel_mask) mask_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      go_q   <= 1'b0;
      len_q  <= '0;
      mask_q <= '0;
    end else begin
      go_q   <= go_d;
      len_q  <= len_d;
      mask_q <= mask_d;
    end
  end

  crc_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n), .push(sel_data), .din(wr_data),
    .pop(pop), .dout(head), .full(fifo_full), .empty(q_empty), .count(fifo_cnt)
  );

  crc_feeder #(.W(W)) u_feed (
    .clk(clk), .rst_n(rst_sync_n), .run(go_q), .len(len_q),
    .src_empty(q_empty), .src_word(head), .pop(pop), .step_en(step_en),
    .bit_out(bit_s), .busy(busy)
  );

  crc_lfsr #(.W(W)) u_lfsr (
    .clk(clk), .rst_n(rst_sync_n), .step_en(step_en), .bit_in(bit_s),
    .load_en(sel_init), .load_val(wr_data), .len(len_q), .mask(mask_q),
    .crc_raw(crc_raw), .crc_res(crc_out)
  );
endmodule

// File: rtl/crc_serial_engine_chk.sv
module crc_serial_engine_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic          go_q,
  input logic          busy,
  input logic          pop,
  input logic [CW-1:0] fifo_cnt,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic [W-1:0]  crc_raw,
  input logic [W-1:0]  mask_q
);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_en && wr_addr == 2'd0 && !pop) |=> fifo_full);

  // R8
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> (fifo_cnt == '0 && !busy));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_q && !(wr_en && wr_addr == 2'd3)) |=> $stable(crc_raw));

  // R9
  mask_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !fifo_empty && wr_en && wr_addr == 2'd2) |=> $stable(mask_q));
endmodule

bind crc_serial_engine crc_serial_engine_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .go_q(go_q), .busy(busy), .pop(pop), .fifo_cnt(fifo_cnt),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .crc_raw(crc_raw),
  .mask_q(mask_q)
);

// File: tb/crc_serial_engine_bench.sv
`timescale 1ns/1ps
module crc_serial_engine_bench;
  logic        clk, rst_n, wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data, crc_out;
  logic        fifo_full, fifo_empty;

  int checks = 0, failures = 0, cyc = 0;
  bit cmp_on = 0, done = 0;

  crc_serial_engine u_crc_serial_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .crc_out(crc_out), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // behavioural reference model
  int          mq[$];
  bit          m_go, m_busy;
  int          m_len, m_cnt;
  logic [15:0] m_mask, m_crc, m_word;

  function automatic logic [15:0] wm(int l);
    return 16'hFFFF >> (15 - l);
  endfunction

  initial begin
    m_go = 0; m_busy = 0; m_len = 0; m_cnt = 0;
    m_mask = 0; m_crc = 0; m_word = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_go = 0; m_busy = 0; m_len = 0; m_cnt = 0;
      m_mask = 0; m_crc = 0;
    end else begin
      bit empty_m, lock, shift, b, top;
      int sz;
      sz = mq.size();
      empty_m = (sz == 0) && !m_busy;
      lock = m_go && !empty_m;
      shift = m_go && (m_busy || sz != 0);
      if (shift) begin
        if (m_busy) begin
          b = m_word[m_cnt];
          if (m_cnt == 0) m_busy = 0; else m_cnt--;
        end else begin
          m_word = mq.pop_front();
          b = m_word[m_len];
          if (m_len == 0) m_busy = 0; else begin m_busy = 1; m_cnt = m_len - 1; end
        end
        top = m_crc[m_len];
        m_crc = ((m_crc << 1) | 16'(b)) & wm(m_len);
        if (top) m_crc = m_crc ^ (m_mask & wm(m_len));
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: if (sz < 8) mq.push_back(int'(wr_data));
          2'd1: begin m_go = wr_data[4]; if (!lock) m_len = int'(wr_data[3:0]); end
          2'd2: if (!lock) m_mask = wr_data;
          default: if (!lock) m_crc = wr_data;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 crc_out vs model", crc_out, m_crc & wm(m_len));
      chk("R7 fifo_full vs model", 16'(fifo_full), 16'(mq.size() == 8));
      chk("R8 fifo_empty vs model", 16'(fifo_empty), 16'(mq.size() == 0 && !m_busy));
    end
  end

  function automatic logic [15:0] crc_calc(logic [15:0] init, logic [15:0] mask,
                                           int l, logic [15:0] w[$]);
    logic [15:0] c;
    logic t;
    c = init;
    foreach (w[i]) begin
      for (int b = l; b >= 0; b--) begin
        t = c[l];
        c = ((c << 1) | 16'(w[i][b])) & wm(l);
        if (t) c = c ^ (mask & wm(l));
      end
    end
    return c & wm(l);
  endfunction

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 1000 && !fifo_empty; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [15:0] held;
    int n;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 crc_out reset", crc_out, 16'h0000);
    chk("R1 empty reset", 16'(fifo_empty), 16'd1);
    chk("R1 full reset", 16'(fifo_full), 16'd0);
    cmp_on = 1;

    // R11 / R4 / R8: known vector and gap-free timing
    wr(2'd1, 16'h000F); wr(2'd2, 16'h1021); wr(2'd3, 16'h0000);
    wr(2'd0, 16'h0051); wr(2'd0, 16'h0000);
    chk("R8 empty low with data queued", 16'(fifo_empty), 16'd0);
    wr(2'd1, 16'h001F);
    n = 0;
    while (!fifo_empty && n < 100) begin n++; @(negedge clk); end
    chk("R4 clocks for two words", 16'(n), 16'd32);
    wr(2'd1, 16'h000F);
    chk("R11 known vector", crc_out, 16'h4AD4);

    // R6 / R5: nonzero start value, pause and resume
    wr(2'd3, 16'hFFFF);
    wr(2'd0, 16'h1234); wr(2'd0, 16'h5678); wr(2'd0, 16'h0000);
    wr(2'd1, 16'h001F);
    repeat (5) @(negedge clk);
    wr(2'd1, 16'h000F);
    held = crc_out;
    repeat (6) @(negedge clk);
    chk("R5 result held while stopped", crc_out, held);
    chk("R5 work kept while stopped", 16'(fifo_empty), 16'd0);
    wr(2'd1, 16'h001F);
    wait_empty();
    wr(2'd1, 16'h000F);
    chk("R6 start value result", crc_out,
        crc_calc(16'hFFFF, 16'h1021, 15, '{16'h1234, 16'h5678, 16'h0000}));

    // R9: config writes ignored during a run
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'h1234); wr(2'd0, 16'h0000);
    wr(2'd1, 16'h001F);
    repeat (3) @(negedge clk);
    wr(2'd2, 16'hFFFF); wr(2'd3, 16'hAAAA); wr(2'd1, 16'h0017);
    wait_empty();
    wr(2'd1, 16'h000F);
    chk("R9 writes ignored while running", crc_out,
        crc_calc(16'h0000, 16'h1021, 15, '{16'h1234, 16'h0000}));

    // R10 / R2: 8-bit CRC
    wr(2'd1, 16'h0007); wr(2'd2, 16'h0007); wr(2'd3, 16'hFFFF);
    chk("R10 upper bits masked", crc_out, 16'h00FF);
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'hAB31); wr(2'd0, 16'hFF00);
    wr(2'd1, 16'h0017);
    wait_empty();
    wr(2'd1, 16'h0007);
    chk("R2 8-bit result, upper data ignored", crc_out,
        crc_calc(16'h0000, 16'h0007, 7, '{16'h0031, 16'h0000}));

    // R7: full flag and dropped write
    wr(2'd1, 16'h000F); wr(2'd2, 16'h8005); wr(2'd3, 16'h0000);
    for (int i = 1; i <= 8; i++) wr(2'd0, 16'(i));
    chk("R7 full after 8 words", 16'(fifo_full), 16'd1);
    wr(2'd0, 16'h0009);
    chk("R7 still full after dropped write", 16'(fifo_full), 16'd1);
    wr(2'd1, 16'h001F);
    @(negedge clk);
    chk("R7 full clears once running", 16'(fifo_full), 16'd0);
    wait_empty();
    wr(2'd1, 16'h000F);
    chk("R7 ninth word dropped", crc_out,
        crc_calc(16'h0000, 16'h8005, 15,
                 '{16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd8}));

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule